// File: doc/BRIEF.md
# Phase-Shift Step Responder

This block is a cycle-level stand-in for the fine phase-adjust engine of a clock manager. Everything happens on the rising edge of one clock. A request is a single cycle of `ps_en` high. `ps_incdec` chooses the direction of that request: high moves the offset up and low moves it down. The block holds a signed phase offset. Each accepted request moves that offset by exactly one unit, or by nothing if the offset is already at the end of its range.

The time from a request to its completion is not fixed. A free-running pseudo-random source draws a fresh wait for each request. During the wait, a finer-grained phase output walks from the old offset to the new one in half-unit sub-steps rather than jumping. Completion is signalled by a one-cycle `ps_done` pulse.

A request that would push the offset past +255 or below -255 is still acknowledged with `ps_done`. In that case the block raises `ps_overflow` and leaves the offset unchanged. Users pulse `ps_en`, then watch for `ps_done` before sending the next request.

Top module: `ps_step_responder`

## Requirements
- R1: After reset, `ps_offset` = 0, `ps_phase` = 0, `ps_done` = 0 and `ps_overflow` = 0, and the block is idle, so it accepts the first request it sees.
- R2: `ps_en` is sampled high on a rising edge while the block is idle. If `ps_incdec` = 1 on that edge, the committed offset rises by one; if `ps_incdec` = 0, it falls by one.
- R3: Each accepted request produces exactly one `ps_done` pulse, and that pulse is exactly one cycle wide.
- R4: Let L be the number of rising edges from the accepting edge up to and including the edge that raises `ps_done`. L lies in 3..18, and L differs between requests.
- R5: `ps_phase` is the offset in half units: one fraction bit, so its value is twice the offset. It changes by at most one half unit per cycle. One cycle before `ps_done` it equals 2·old±1. In the `ps_done` cycle it equals 2·new.
- R6: `ps_offset` changes only on the edge that raises `ps_done`.
- R7: An increment request while the offset is +255 still yields one `ps_done` pulse. On that pulse `ps_overflow` = 1, and neither `ps_offset` nor `ps_phase` changes.
- R8: A decrement request while the offset is -255 behaves the same way: `ps_done` pulses, `ps_overflow` = 1, and the offset is unchanged.
- R9: A step that does move the offset clears `ps_overflow`. After a limit hit, such a step is necessarily in the opposite direction. `ps_overflow` changes only on the edge that raises `ps_done`.
- R10: A `ps_en` pulse that arrives while a step is in progress is ignored. It produces no extra `ps_done` and no extra change of offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ps_clk | input | 1 | Phase-shift clock; all inputs and outputs are timed to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ps_en | input | 1 | One-cycle step request |
| ps_incdec | input | 1 | Step direction: 1 = up, 0 = down |
| ps_done | output | 1 | One-cycle completion pulse |
| ps_overflow | output | 1 | Last completed request hit the range limit |
| ps_offset | output | 9 | Committed signed offset, -255..+255 |
| ps_phase | output | 10 | Signed fine phase in half units, moves gradually |

## Verification
A request sampled on edge E0 raises `ps_done` in the cycle after edge E0+L. The committed offset and the overflow flag update on that same edge. The first half-unit of `ps_phase` moves one edge earlier, at E0+L-1. Because L is drawn internally, the bench does not predict it. Instead it samples every cycle at the falling edge after E0 and treats the first cycle with `ps_done` high as the completion cycle. It checks that L lies in range, that the sample before completion shows exactly the half step, and that the offset was unchanged in every earlier sample. After completion it watches one further cycle for the end of the pulse. After a mid-step `ps_en` it watches 24 further cycles, longer than any possible latency, to confirm that no second completion arrives.

// File: rtl/ps_step_pkg.sv
package ps_step_pkg;

    // pseudo-random source width (fixed polynomial below)
    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'hA5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } step_state_e;

    // request captured at acceptance
    typedef struct packed {
        logic up;       // 1: move up, 0: move down
        logic blocked;  // offset already at the limit in that direction
    } step_req_t;

    // x^8 + x^6 + x^5 + x^4 + 1, maximal length
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/ps_lat_lfsr.sv
module ps_lat_lfsr
    import ps_step_pkg::*;
#(
    parameter int LAT_MIN = 3,
    parameter int SPAN_W  = 4,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] lat
);
    logic [LFSR_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= LFSR_SEED;
        else     sr <= lfsr_next(sr);
    end

    // minimum wait plus a pseudo-random span
    assign lat = CNT_W'(LAT_MIN) + CNT_W'(sr[SPAN_W-1:0]);
endmodule

// File: rtl/ps_step_ctrl.sv
module ps_step_ctrl
    import ps_step_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int SUBS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_en,
    input  logic             req_up,
    input  logic             at_top,
    input  logic             at_bot,
    input  logic [CNT_W-1:0] lat,
    output logic             busy,
    output logic             sub_step,
    output logic             step_up,
    output logic             commit,
    output logic             blocked,
    output logic             done
);
    step_state_e state;
    step_req_t   req;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_en) begin
                        state       <= ST_BUSY;
                        cnt         <= lat;
                        req.up      <= req_up;
                        req.blocked <= req_up ? at_top : at_bot;
                    end
                end
                ST_BUSY: begin
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state == ST_BUSY);
    // the sub-steps occupy the last SUBS cycles of the wait
    assign sub_step = busy && (cnt <= CNT_W'(SUBS)) && !req.blocked;
    assign commit   = busy && (cnt == CNT_W'(1));
    assign step_up  = req.up;
    assign blocked  = req.blocked;
endmodule

// File: rtl/ps_phase_acc.sv
module ps_phase_acc #(
    parameter int OFS_MAX   = 255,
    parameter int OFS_W     = 9,
    parameter int FRAC_BITS = 1,
    parameter int PH_W      = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sub_step,
    input  logic                    step_up,
    input  logic                    commit,
    input  logic                    blocked,
    output logic signed [OFS_W-1:0] offset,
    output logic signed [PH_W-1:0]  phase,
    output logic                    ovf,
    output logic                    at_top,
    output logic                    at_bot
);
    localparam logic signed [OFS_W-1:0] TOP = OFS_W'(OFS_MAX);
    localparam logic signed [OFS_W-1:0] BOT = -TOP;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            phase  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (sub_step)
                phase <= step_up ? phase + PH_W'(1) : phase - PH_W'(1);
            if (commit) begin
                if (blocked) begin
                    ovf <= 1'b1;
                end else begin
                    ovf    <= 1'b0;
                    offset <= step_up ? offset + OFS_W'(1) : offset - OFS_W'(1);
                end
            end
        end
    end

    assign at_top = (offset == TOP);
    assign at_bot = (offset == BOT);
endmodule

// File: rtl/ps_step_responder.sv
module ps_step_responder #(
    parameter int OFS_MAX   = 255,
    parameter int FRAC_BITS = 1,
    parameter int LAT_MIN   = 3,
    parameter int SPAN_W    = 4,
    localparam int OFS_W    = $clog2(OFS_MAX + 1) + 1,
    localparam int PH_W     = OFS_W + FRAC_BITS
) (
    input  logic                    ps_clk,
    input  logic                    rst,
    input  logic                    ps_en,
    input  logic                    ps_incdec,
    output logic                    ps_done,
    output logic                    ps_overflow,
    output logic signed [OFS_W-1:0] ps_offset,
    output logic signed [PH_W-1:0]  ps_phase
);
    localparam int SUBS    = 1 << FRAC_BITS;
    localparam int LAT_MAX = LAT_MIN + (1 << SPAN_W) - 1;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    logic [CNT_W-1:0] lat;
    logic busy, sub_step, step_up, commit, blocked, at_top, at_bot;

    initial begin
        if (LAT_MIN < SUBS) $error("wait shorter than the sub-step count");
    end

    ps_lat_lfsr #(
        .LAT_MIN(LAT_MIN), .SPAN_W(SPAN_W), .CNT_W(CNT_W)
    ) u_lat (
        .clk(ps_clk), .rst(rst), .lat(lat)
    );

    ps_step_ctrl #(
        .CNT_W(CNT_W), .SUBS(SUBS)
    ) u_ctrl (
        .clk(ps_clk), .rst(rst),
        .req_en(ps_en), .req_up(ps_incdec),
        .at_top(at_top), .at_bot(at_bot), .lat(lat),
        .busy(busy), .sub_step(sub_step), .step_up(step_up),
        .commit(commit), .blocked(blocked), .done(ps_done)
    );

    ps_phase_acc #(
        .OFS_MAX(OFS_MAX), .OFS_W(OFS_W), .FRAC_BITS(FRAC_BITS), .PH_W(PH_W)
    ) u_acc (
        .clk(ps_clk), .rst(rst),
        .sub_step(sub_step), .step_up(step_up),
        .commit(commit), .blocked(blocked),
        .offset(ps_offset), .phase(ps_phase), .ovf(ps_overflow),
        .at_top(at_top), .at_bot(at_bot)
    );
endmodule

// File: rtl/ps_step_responder_chk.sv
module ps_step_responder_chk #(
    parameter int OFS_MAX   = 255,
    parameter int OFS_W     = 9,
    parameter int FRAC_BITS = 1,
    parameter int PH_W      = 10,
    parameter int LAT_MIN   = 3,
    parameter int LAT_MAX   = 18
) (
    input logic                    ps_clk,
    input logic                    rst,
    input logic                    ps_done,
    input logic                    ps_overflow,
    input logic signed [OFS_W-1:0] ps_offset,
    input logic signed [PH_W-1:0]  ps_phase,
    input logic                    busy
);
    localparam logic signed [OFS_W-1:0] TOP = OFS_W'(OFS_MAX);
    localparam logic signed [OFS_W-1:0] BOT = -TOP;

    // cycles spent busy, saturating
    logic [7:0] wait_cnt;
    always_ff @(posedge ps_clk) begin
        if (rst)                wait_cnt <= '0;
        else if (!busy)         wait_cnt <= '0;
        else if (wait_cnt != '1) wait_cnt <= wait_cnt + 8'd1;
    end

    // R3
    done_width_chk: assert property (@(posedge ps_clk) disable iff (rst)
        ps_done |=> !ps_done);

    // R4
    latency_window_chk: assert property (@(posedge ps_clk) disable iff (rst)
        $rose(ps_done) |-> (int'(wait_cnt) >= LAT_MIN) && (int'(wait_cnt) <= LAT_MAX));

    // R5
    phase_glide_chk: assert property (@(posedge ps_clk) disable iff (rst)
        (ps_phase == $past(ps_phase)) ||
        (ps_phase == $past(ps_phase) + PH_W'(1)) ||
        (ps_phase == $past(ps_phase) - PH_W'(1)));

    // R5
    phase_settled_chk: assert property (@(posedge ps_clk) disable iff (rst)
        ps_done |-> ps_phase == {ps_offset, {FRAC_BITS{1'b0}}});

    // R6
    offset_on_done_chk: assert property (@(posedge ps_clk) disable iff (rst)
        (ps_offset != $past(ps_offset)) |-> ps_done);

    // R7
    offset_range_chk: assert property (@(posedge ps_clk) disable iff (rst)
        (ps_offset <= TOP) && (ps_offset >= BOT));

    // R8
    no_overflow_move_chk: assert property (@(posedge ps_clk) disable iff (rst)
        (ps_done && ps_overflow) |-> ps_offset == $past(ps_offset));

    // R9
    overflow_on_done_chk: assert property (@(posedge ps_clk) disable iff (rst)
        (ps_overflow != $past(ps_overflow)) |-> ps_done);
endmodule

bind ps_step_responder ps_step_responder_chk #(
    .OFS_MAX(OFS_MAX), .OFS_W(OFS_W), .FRAC_BITS(FRAC_BITS), .PH_W(PH_W),
    .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)
) u_chk (
    .ps_clk(ps_clk), .rst(rst), .ps_done(ps_done), .ps_overflow(ps_overflow),
    .ps_offset(ps_offset), .ps_phase(ps_phase), .busy(busy)
);

// File: tb/ps_step_responder_bench.sv
module ps_step_responder_bench;

    logic ps_clk = 1'b0;
    logic rst = 1'b1;
    logic ps_en = 1'b0;
    logic ps_incdec = 1'b0;
    logic ps_done, ps_overflow;
    logic signed [8:0] ps_offset;
    logic signed [9:0] ps_phase;

    int checks = 0;
    int errors = 0;
    int cur_off = 0;
    logic [63:0] lat_seen = '0;

    always #2.5 ps_clk = ~ps_clk;   // 200 MHz

    ps_step_responder u_ps_step_responder (
        .ps_clk(ps_clk), .rst(rst), .ps_en(ps_en), .ps_incdec(ps_incdec),
        .ps_done(ps_done), .ps_overflow(ps_overflow),
        .ps_offset(ps_offset), .ps_phase(ps_phase)
    );

    typedef struct packed {
        logic              up;
        logic signed [15:0] off;
        logic              ovf;
    } vec_t;

    localparam int VEC_N = 8;
    localparam vec_t VECS [0:VEC_N-1] = '{
        '{1'b1,  16'sd1, 1'b0},
        '{1'b1,  16'sd2, 1'b0},
        '{1'b1,  16'sd3, 1'b0},
        '{1'b0,  16'sd2, 1'b0},
        '{1'b0,  16'sd1, 1'b0},
        '{1'b0,  16'sd0, 1'b0},
        '{1'b0, -16'sd1, 1'b0},
        '{1'b1,  16'sd0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_req(input logic up, input logic poke, input int exp_off,
                           input logic exp_ovf, input string tag);
        int old_off, step, k, prev_ph, d, tail;
        bit seen;
        old_off = cur_off;
        step = (exp_off == old_off) ? 0 : (up ? 1 : -1);
        ps_incdec = up;
        ps_en = 1'b1;
        @(posedge ps_clk);
        @(negedge ps_clk);
        ps_en = 1'b0;
        prev_ph = int'(ps_phase);
        k = 0;
        seen = 0;
        while (!seen && k < 40) begin
            @(negedge ps_clk);
            k++;
            if (poke) ps_en = (k == 1);
            d = int'(ps_phase) - prev_ph;
            check(d == 0 || d == step, "R5", d, step);
            if (ps_done) begin
                seen = 1;
                check(k >= 3 && k <= 18, "R4", k, 3);
                if (k < 64) lat_seen[k] = 1'b1;
                check(int'(ps_offset) == exp_off, tag, int'(ps_offset), exp_off);
                check(ps_overflow == exp_ovf, (exp_ovf ? tag : "R9"),
                      int'(ps_overflow), int'(exp_ovf));
                check(int'(ps_phase) == 2 * exp_off, "R5", int'(ps_phase), 2 * exp_off);
                check(prev_ph == 2 * old_off + step, "R5", prev_ph, 2 * old_off + step);
            end else begin
                check(int'(ps_offset) == old_off, "R6", int'(ps_offset), old_off);
            end
            prev_ph = int'(ps_phase);
        end
        ps_en = 1'b0;
        if (!seen) check(1'b0, "R3", 0, 1);
        cur_off = exp_off;
        tail = poke ? 24 : 1;
        for (int i = 0; i < tail; i++) begin
            @(negedge ps_clk);
            check(!ps_done, poke ? "R10" : "R3", int'(ps_done), 0);
            check(int'(ps_offset) == exp_off, poke ? "R10" : "R3", int'(ps_offset), exp_off);
        end
    endtask

    task automatic check_reset_state();
        check(int'(ps_offset) == 0, "R1", int'(ps_offset), 0);
        check(int'(ps_phase) == 0, "R1", int'(ps_phase), 0);
        check(!ps_done, "R1", int'(ps_done), 0);
        check(!ps_overflow, "R1", int'(ps_overflow), 0);
    endtask

    initial begin
        repeat (150000) @(posedge ps_clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge ps_clk);
        rst = 1'b0;
        @(negedge ps_clk);
        check_reset_state();   // R1

        // table walk: R2 up/down around zero
        for (int v = 0; v < VEC_N; v++)
            run_req(VECS[v].up, 1'b0, int'(VECS[v].off), VECS[v].ovf, "R2");

        // R10: request pulse during a busy step
        run_req(1'b1, 1'b1, 1, 1'b0, "R10");
        run_req(1'b0, 1'b1, 0, 1'b0, "R10");

        // ramp to the upper limit
        for (int i = 1; i <= 255; i++) run_req(1'b1, 1'b0, i, 1'b0, "R2");
        // R7: increment at +255
        run_req(1'b1, 1'b0, 255, 1'b1, "R7");
        run_req(1'b1, 1'b0, 255, 1'b1, "R7");
        // R9: opposite step clears overflow
        run_req(1'b0, 1'b0, 254, 1'b0, "R9");

        // ramp to the lower limit
        for (int i = 253; i >= -255; i--) run_req(1'b0, 1'b0, i, 1'b0, "R2");
        // R8: decrement at -255
        run_req(1'b0, 1'b0, -255, 1'b1, "R8");
        run_req(1'b1, 1'b0, -254, 1'b0, "R9");

        // R4: waits differ between requests
        check($countones(lat_seen) >= 3, "R4", $countones(lat_seen), 3);

        // R1: reset from a non-zero state with overflow set
        run_req(1'b0, 1'b0, -255, 1'b0, "R2");
        run_req(1'b0, 1'b0, -255, 1'b1, "R8");
        rst = 1'b1;
        repeat (2) @(negedge ps_clk);
        rst = 1'b0;
        @(negedge ps_clk);
        check_reset_state();
        cur_off = 0;
        run_req(1'b1, 1'b0, 1, 1'b0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule